// File: doc/BRIEF.md
# Remote Terminal Response Sequencer

This block runs the reply of a serial-bus remote terminal to one command that upstream decoding has already accepted on the active bus. A one-cycle start pulse delivers the 16-bit command word. The block waits a fixed response delay, then opens a status-word slot. It takes the status value from a host-writable register late inside that slot, so that a host which marks a command illegal still has time to set the message-error bit. It then opens one slot per transmit data word and pulls each word from a show-ahead FIFO at that slot's mid-sync point. Every timing value is given in nanoseconds and converted to clock cycles from a clock-frequency parameter.

Each message ends in one of three ways. It can complete cleanly, which raises a valid-message level. It can fail, which raises an error level and records an error code. It can also end silently, with neither level raised. A silent end happens when the host has set the data-suppress control bit, or for a broadcast mode command that carries no data word. The words go to the transmitter as a slot-start strobe followed by a word-load strobe. Bit encoding, the PHY and the FIFO storage lie outside the block.

Command word fields: bits 15:11 hold the terminal address, and address 31 means broadcast. Bit 10 is transmit (1) or receive (0). Bits 9:5 hold the subaddress, and 0 or 31 marks a mode command. Bits 4:0 hold the word count, or the mode code for a mode command.

Top module: `rt_reply_seq`

## Requirements
- R1: For a non-broadcast command with control bit 0 (transmit enable) set, `tx_sync` and `tx_stat_sync` pulse together exactly RESP cycles after the accepting clock edge (400 cycles, which is 8 µs at 50 MHz).
- R2: `tx_load` pulses LOAD cycles after the status slot start (140 cycles, which is 1.5 µs mid-sync plus 1.3 µs). `tx_word` then carries the value of `stat_word` as sampled at that edge, so host writes made up to that point take effect.
- R3: A transmit command sends a number of data words equal to its word count, and a count of 0 means 32. A transmit mode command with code bit 4 set sends one word. Each data slot starts WORD cycles (1000) after the previous slot. At its mid-sync offset MID (75 cycles), the block pulses `fifo_rd` and `tx_load` together with the FIFO head word.
- R4: If the FIFO is empty at a data slot's mid-sync, the message ends at that edge. `msg_err` is raised with `err_code` = 1, and no further word is sent.
- R5: A clean message raises `msg_ok` at the end of its last slot, with `err_code` = 0. `msg_ok` and `msg_err` are never high together. Both hold until the next accepted command, which clears them at its accepting edge.
- R6: If control bit 13 is set at the end of the status slot, no data words are sent. The message ends at that edge with both `msg_ok` and `msg_err` low.
- R7: A broadcast command (address 31) gets no status word and ends RESP cycles after acceptance. A broadcast transmit command raises `msg_err` with `err_code` = 2. A broadcast mode command with code bit 4 clear ends silently. Any other broadcast command raises `msg_ok`.
- R8: A non-broadcast command with transmit enable clear sends nothing. It ends RESP cycles after acceptance with `msg_err` and `err_code` = 3.
- R9: A start pulse while a message is running is accepted only when at least GAP cycles (200, which is 4 µs) have passed since the last accepted start. An accepted pulse aborts the running message and restarts the delay. An earlier pulse is ignored.
- R10: After reset, `busy`, `msg_ok`, `msg_err`, `tx_sync`, `tx_load`, `fifo_rd` and `err_code` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_go | input | 1 | One-cycle pulse: accepted command present |
| cmd_word | input | 16 | Command word, valid with `cmd_go` |
| stat_word | input | 16 | Host status register |
| ctrl_word | input | 16 | Host control register: bit 0 transmit enable, bit 13 suppress data |
| fifo_empty | input | 1 | Transmit FIFO empty |
| fifo_data | input | 16 | FIFO head word (show-ahead) |
| fifo_rd | output | 1 | Pop strobe for the FIFO head |
| tx_sync | output | 1 | Start of a word slot |
| tx_stat_sync | output | 1 | With `tx_sync`: slot carries the status word |
| tx_load | output | 1 | `tx_word` is valid for the current slot |
| tx_word | output | 16 | Word handed to the transmitter |
| busy | output | 1 | A message is in progress |
| msg_ok | output | 1 | Last message completed cleanly |
| msg_err | output | 1 | Last message ended in error |
| err_code | output | 2 | Error kind: 0 none, 1 FIFO underrun, 2 broadcast transmit, 3 transmit disabled |

## Verification
A phase counter or slot counter that drifts shows at once as a misplaced `tx_sync` or `tx_load`. Since every event is compared at an exact cycle offset, the fault appears in the first message it affects. A wrong remaining-word count shows as an extra or missing data slot. It also shows as a completion level raised one word time too early or too late. A corrupted decoded-command register shows on the next message, either as the wrong ending (status versus none, or ok versus error code) or as a status slot sent for broadcast.

// File: rtl/rt_seq_pkg.sv
package rt_seq_pkg;

   localparam int WORD_W = 16;
   localparam int NW_W   = 6;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WAIT,
      ST_STAT,
      ST_DATA
   } seq_state_t;

   typedef enum logic [1:0] {
      ERR_NONE     = 2'd0,
      ERR_UNDERRUN = 2'd1,
      ERR_BCAST_TX = 2'd2,
      ERR_TX_OFF   = 2'd3
   } err_kind_t;

   typedef struct packed {
      logic            bcast;
      logic            xmit;
      logic            mode;
      logic            silent_bc;
      logic [NW_W-1:0] nwords;
   } cmd_info_t;

endpackage

// File: rtl/rt_cmd_decode.sv
module rt_cmd_decode
   import rt_seq_pkg::*;
#(
   parameter int BCAST_ADDR   = 31,
   parameter bit SA31_IS_MODE = 1'b1
) (
   input  logic [WORD_W-1:0] cw,
   output cmd_info_t         info
);

   logic [4:0] addr;
   logic [4:0] sub;
   logic [4:0] cnt;
   logic       is_mode;

   assign addr = cw[15:11];
   assign sub  = cw[9:5];
   assign cnt  = cw[4:0];

   generate
      if (SA31_IS_MODE) begin : g_two_mode_sa
         assign is_mode = (sub == 5'd0) || (sub == 5'd31);
      end else begin : g_one_mode_sa
         assign is_mode = (sub == 5'd0);
      end
   endgenerate

   always_comb begin
      info.bcast     = (addr == 5'(BCAST_ADDR));
      info.xmit      = cw[10];
      info.mode      = is_mode;
      info.silent_bc = is_mode && !cnt[4];
      if (is_mode)
         info.nwords = (cw[10] && cnt[4]) ? NW_W'(1) : '0;
      else if (cw[10])
         info.nwords = (cnt == 5'd0) ? NW_W'(32) : NW_W'(cnt);
      else
         info.nwords = '0;
   end

endmodule

// File: rtl/rt_phase_timer.sv
module rt_phase_timer #(
   parameter int RESP_CYC = 400,
   parameter int LOAD_CYC = 140,
   parameter int MID_CYC  = 75,
   parameter int WORD_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic at_resp,
   output logic at_load,
   output logic at_mid,
   output logic at_end
);

   localparam int MAXC = (RESP_CYC > WORD_CYC) ? RESP_CYC : WORD_CYC;
   localparam int TW   = $clog2(MAXC + 1);

   logic [TW-1:0] tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tick <= '0;
      else if (restart)
         tick <= '0;
      else if (tick != TW'(MAXC))
         tick <= tick + 1'b1;
   end

   assign at_resp = (tick == TW'(RESP_CYC - 1));
   assign at_load = (tick == TW'(LOAD_CYC - 1));
   assign at_mid  = (tick == TW'(MID_CYC - 1));
   assign at_end  = (tick == TW'(WORD_CYC - 1));

endmodule

// File: rtl/rt_reply_seq.sv
module rt_reply_seq
   import rt_seq_pkg::*;
#(
   parameter int CLK_MHZ      = 50,
   parameter int RESP_NS      = 8000,
   parameter int WORD_NS      = 20000,
   parameter int MIDSYNC_NS   = 1500,
   parameter int LATE_NS      = 1300,
   parameter int GAP_NS       = 4000,
   parameter int BCAST_ADDR   = 31,
   parameter bit SA31_IS_MODE = 1'b1,
   parameter int TXEN_BIT     = 0,
   parameter int SUPP_BIT     = 13
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_go,
   input  logic [15:0] cmd_word,
   input  logic [15:0] stat_word,
   input  logic [15:0] ctrl_word,
   input  logic        fifo_empty,
   input  logic [15:0] fifo_data,
   output logic        fifo_rd,
   output logic        tx_sync,
   output logic        tx_stat_sync,
   output logic        tx_load,
   output logic [15:0] tx_word,
   output logic        busy,
   output logic        msg_ok,
   output logic        msg_err,
   output logic [1:0]  err_code
);

   localparam int RESP_CYC = RESP_NS * CLK_MHZ / 1000;
   localparam int WORD_CYC = WORD_NS * CLK_MHZ / 1000;
   localparam int MID_CYC  = MIDSYNC_NS * CLK_MHZ / 1000;
   localparam int LOAD_CYC = (MIDSYNC_NS + LATE_NS) * CLK_MHZ / 1000;
   localparam int GAP_CYC  = GAP_NS * CLK_MHZ / 1000;
   localparam int GW       = $clog2(GAP_CYC + 1);

   generate
      if (RESP_NS < 7000 || RESP_NS > 9000) begin : g_bad_resp
         $error("response delay must lie in 7..9 us");
      end
      if (MID_CYC < 1 || LOAD_CYC >= WORD_CYC) begin : g_bad_slot
         $error("slot offsets must fit inside one word slot");
      end
      if (TXEN_BIT > 15 || SUPP_BIT > 15 || TXEN_BIT == SUPP_BIT) begin : g_bad_bits
         $error("control bit positions invalid");
      end
   endgenerate

   seq_state_t      state;
   cmd_info_t       dec_now;
   cmd_info_t       dec_q;
   logic [NW_W-1:0] left;
   logic [GW-1:0]   since;
   err_kind_t       err_q;
   logic            accept;
   logic            slot_start;
   logic            at_resp, at_load, at_mid, at_end;
   logic            txen, supp;

   rt_cmd_decode #(
      .BCAST_ADDR  (BCAST_ADDR),
      .SA31_IS_MODE(SA31_IS_MODE)
   ) u_dec (
      .cw  (cmd_word),
      .info(dec_now)
   );

   assign txen   = ctrl_word[TXEN_BIT];
   assign supp   = ctrl_word[SUPP_BIT];
   assign accept = cmd_go && ((state == ST_IDLE) || (since == GW'(GAP_CYC)));

   always_comb begin
      slot_start = 1'b0;
      unique case (state)
         ST_WAIT: slot_start = at_resp && !dec_q.bcast && txen;
         ST_STAT: slot_start = at_end && !supp && (left != '0);
         ST_DATA: slot_start = at_end && (left != '0);
         default: slot_start = 1'b0;
      endcase
   end

   rt_phase_timer #(
      .RESP_CYC(RESP_CYC),
      .LOAD_CYC(LOAD_CYC),
      .MID_CYC (MID_CYC),
      .WORD_CYC(WORD_CYC)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .restart(accept || slot_start),
      .at_resp(at_resp),
      .at_load(at_load),
      .at_mid (at_mid),
      .at_end (at_end)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since <= '0;
      else if (accept)
         since <= '0;
      else if (since != GW'(GAP_CYC))
         since <= since + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state        <= ST_IDLE;
         dec_q        <= '0;
         left         <= '0;
         err_q        <= ERR_NONE;
         msg_ok       <= 1'b0;
         msg_err      <= 1'b0;
         tx_sync      <= 1'b0;
         tx_stat_sync <= 1'b0;
         tx_load      <= 1'b0;
         tx_word      <= '0;
         fifo_rd      <= 1'b0;
      end else begin
         tx_sync      <= 1'b0;
         tx_stat_sync <= 1'b0;
         tx_load      <= 1'b0;
         fifo_rd      <= 1'b0;
         if (accept) begin
            state   <= ST_WAIT;
            dec_q   <= dec_now;
            err_q   <= ERR_NONE;
            msg_ok  <= 1'b0;
            msg_err <= 1'b0;
         end else begin
            unique case (state)
               ST_WAIT: if (at_resp) begin
                  if (dec_q.bcast) begin
                     state <= ST_IDLE;
                     if (dec_q.xmit) begin
                        msg_err <= 1'b1;
                        err_q   <= ERR_BCAST_TX;
                     end else if (!dec_q.silent_bc || !dec_q.mode) begin
                        msg_ok <= 1'b1;
                     end
                  end else if (!txen) begin
                     state   <= ST_IDLE;
                     msg_err <= 1'b1;
                     err_q   <= ERR_TX_OFF;
                  end else begin
                     state        <= ST_STAT;
                     tx_sync      <= 1'b1;
                     tx_stat_sync <= 1'b1;
                     left         <= dec_q.nwords;
                  end
               end
               ST_STAT: begin
                  if (at_load) begin
                     tx_load <= 1'b1;
                     tx_word <= stat_word;
                  end
                  if (at_end) begin
                     if (supp) begin
                        state <= ST_IDLE;
                     end else if (left == '0) begin
                        state  <= ST_IDLE;
                        msg_ok <= 1'b1;
                     end else begin
                        state   <= ST_DATA;
                        tx_sync <= 1'b1;
                     end
                  end
               end
               ST_DATA: begin
                  if (at_mid) begin
                     if (fifo_empty) begin
                        state   <= ST_IDLE;
                        msg_err <= 1'b1;
                        err_q   <= ERR_UNDERRUN;
                     end else begin
                        tx_load <= 1'b1;
                        fifo_rd <= 1'b1;
                        tx_word <= fifo_data;
                        left    <= left - 1'b1;
                     end
                  end
                  if (at_end) begin
                     if (left == '0) begin
                        state  <= ST_IDLE;
                        msg_ok <= 1'b1;
                     end else begin
                        tx_sync <= 1'b1;
                     end
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign busy     = (state != ST_IDLE);
   assign err_code = err_q;

endmodule

// File: rtl/rt_reply_seq_chk.sv
module rt_reply_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_go,
   input logic       fifo_empty,
   input logic       fifo_rd,
   input logic       tx_sync,
   input logic       tx_load,
   input logic       busy,
   input logic       msg_ok,
   input logic       msg_err,
   input logic [1:0] err_code
);

   AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(msg_ok && msg_err)); // R5

   AST_OK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_ok && !cmd_go) |=> msg_ok); // R5

   AST_OK_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      msg_ok |-> (err_code == 2'd0)); // R5

   AST_ERR_CODED: assert property (@(posedge clk) disable iff (!rst_n)
      msg_err |-> (err_code != 2'd0)); // R4

   AST_RD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> $past(!fifo_empty)); // R4

   AST_RD_WITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_rd |-> (tx_load && !tx_sync)); // R3

   AST_SYNC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_sync |-> busy); // R1

endmodule

bind rt_reply_seq rt_reply_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_go    (cmd_go),
   .fifo_empty(fifo_empty),
   .fifo_rd   (fifo_rd),
   .tx_sync   (tx_sync),
   .tx_load   (tx_load),
   .busy      (busy),
   .msg_ok    (msg_ok),
   .msg_err   (msg_err),
   .err_code  (err_code)
);

// File: tb/rt_reply_seq_bench.sv
module rt_reply_seq_bench;

   localparam int RESP = 400;
   localparam int WORD = 1000;
   localparam int MID  = 75;
   localparam int LOAD = 140;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_go = 1'b0;
   logic [15:0] cmd_word = '0;
   logic [15:0] stat_word = '0;
   logic [15:0] ctrl_word = 16'h0001;
   logic        fifo_empty;
   logic [15:0] fifo_data;
   logic        fifo_rd, tx_sync, tx_stat_sync, tx_load, busy, msg_ok, msg_err;
   logic [15:0] tx_word;
   logic [1:0]  err_code;

   always #10 clk = ~clk;

   rt_reply_seq u_rt_reply_seq (
      .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_word(cmd_word),
      .stat_word(stat_word), .ctrl_word(ctrl_word), .fifo_empty(fifo_empty),
      .fifo_data(fifo_data), .fifo_rd(fifo_rd), .tx_sync(tx_sync),
      .tx_stat_sync(tx_stat_sync), .tx_load(tx_load), .tx_word(tx_word),
      .busy(busy), .msg_ok(msg_ok), .msg_err(msg_err), .err_code(err_code)
   );

   // FIFO model, show-ahead
   logic [15:0] fq [0:63];
   logic [7:0]  wp = '0;
   logic [7:0]  rp = '0;
   assign fifo_empty = (wp == rp);
   assign fifo_data  = fq[rp[5:0]];
   always @(posedge clk) if (fifo_rd) rp <= rp + 8'd1;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int n_chk = 0;
   int n_err = 0;

   // logs
   int sy_n, ld_n, end_t;
   int sy_t [0:40];
   int sy_s [0:40];
   int ld_t [0:40];
   int ld_w [0:40];
   // expectation
   int e_nsync, e_nload, e_end, e_ok, e_err, e_code;
   int e_ld_t [0:40];
   int e_ld_w [0:40];

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic int nwords_of(input logic [15:0] c);
      logic mode;
      mode = (c[9:5] == 5'd0) || (c[9:5] == 5'd31);
      if (mode) return (c[10] && c[4]) ? 1 : 0;
      if (c[10]) return (c[4:0] == 5'd0) ? 32 : int'(c[4:0]);
      return 0;
   endfunction

   task automatic expect_of(input logic [15:0] c, input logic [15:0] ctl,
                            input int avail, input int stv, input int base);
      int nw, k;
      logic mode;
      mode = (c[9:5] == 5'd0) || (c[9:5] == 5'd31);
      nw = nwords_of(c);
      e_nsync = 0; e_nload = 0; e_ok = 0; e_err = 0; e_code = 0;
      if (c[15:11] == 5'd31) begin
         e_end = RESP;
         if (c[10]) begin e_err = 1; e_code = 2; end
         else if (!(mode && !c[4])) e_ok = 1;
      end else if (!ctl[0]) begin
         e_end = RESP; e_err = 1; e_code = 3;
      end else begin
         e_nsync = 1; e_nload = 1;
         e_ld_t[0] = RESP + LOAD; e_ld_w[0] = stv;
         if (ctl[13]) e_end = RESP + WORD;
         else if (nw == 0) begin e_end = RESP + WORD; e_ok = 1; end
         else begin
            k = (avail < nw) ? avail : nw;
            for (int i = 1; i <= k; i++) begin
               e_ld_t[i] = RESP + i*WORD + MID;
               e_ld_w[i] = (base + i - 1) & 16'hFFFF;
            end
            e_nload = k + 1;
            if (avail < nw) begin
               e_nsync = k + 2;
               e_end = RESP + (k+1)*WORD + MID; e_err = 1; e_code = 1;
            end else begin
               e_nsync = nw + 1;
               e_end = RESP + (nw+1)*WORD; e_ok = 1;
            end
         end
      end
   endtask

   // run one message; optional second start pulse at offset inj_at
   task automatic run_msg(input string tag, input logic [15:0] c,
                          input logic [15:0] ctl, input int avail,
                          input int inj_at, input logic [15:0] inj_w);
      int t0, rel, base, guard, stv;
      logic [15:0] eff;
      logic inj_ok;
      base = $urandom & 16'hFF00;
      stv = $urandom & 16'hFFFF;
      @(negedge clk);
      rp = wp;
      wp = rp;
      for (int i = 0; i < avail; i++) begin
         fq[(wp + 8'(i)) & 8'h3F] = 16'((base + i) & 16'hFFFF);
      end
      wp = wp + 8'(avail);
      ctrl_word = ctl;
      stat_word = 16'h0;
      cmd_word = c; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
      t0 = cyc; eff = c; inj_ok = 1'b0;
      chk({tag, " R5 flags clear on accept"}, int'(msg_ok) + int'(msg_err), 0);
      sy_n = 0; ld_n = 0; guard = 0;
      while (busy && guard < 40000) begin
         rel = cyc - t0;
         if (tx_sync) begin sy_t[sy_n] = rel; sy_s[sy_n] = int'(tx_stat_sync); if (sy_n < 40) sy_n++; end
         if (tx_load) begin ld_t[ld_n] = rel; ld_w[ld_n] = int'(tx_word); if (ld_n < 40) ld_n++; end
         if (rel == RESP + LOAD - 3) stat_word = 16'(stv);
         if (rel == RESP + LOAD + 2) stat_word = ~16'(stv);
         if (rel == inj_at && !inj_ok) begin
            cmd_word = inj_w; cmd_go = 1'b1;
            @(negedge clk);
            cmd_go = 1'b0;
            if (inj_at >= 200) begin
               t0 = cyc; eff = inj_w; inj_ok = 1'b1;
               sy_n = 0; ld_n = 0;
            end
         end else begin
            @(negedge clk);
         end
         guard++;
      end
      end_t = cyc - t0;
      expect_of(eff, ctl, avail, stv, base);
      chk({tag, " R1 sync count"}, sy_n, e_nsync);
      if (e_nsync > 0 && sy_n > 0) begin
         chk({tag, " R1 status sync time"}, sy_t[0], RESP);
         chk({tag, " R1 status sync flag"}, sy_s[0], 1);
      end
      chk({tag, " R3 load count"}, ld_n, e_nload);
      for (int i = 0; i < e_nload && i < ld_n; i++) begin
         chk({tag, (i == 0) ? " R2 status load time" : " R3 data load time"}, ld_t[i], e_ld_t[i]);
         chk({tag, (i == 0) ? " R2 status word" : " R3 data word"}, ld_w[i], e_ld_w[i]);
      end
      for (int i = 1; i < e_nsync && i < sy_n; i++)
         chk({tag, " R3 data slot spacing"}, sy_t[i], RESP + i*WORD);
      chk({tag, " R5 end time"}, end_t, e_end);
      chk({tag, " R5 msg_ok"}, int'(msg_ok), e_ok);
      chk({tag, " R4 msg_err"}, int'(msg_err), e_err);
      chk({tag, " R8 err_code"}, int'(err_code), e_code);
      repeat (5) @(negedge clk);
      chk({tag, " R5 flags held"}, int'(msg_ok)*2 + int'(msg_err), e_ok*2 + e_err);
   endtask

   function automatic logic [15:0] mk(input int addr, input int tx, input int sa, input int cnt);
      return {5'(addr), 1'(tx), 5'(sa), 5'(cnt)};
   endfunction

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 busy", int'(busy), 0);
      chk("R10 flags", int'(msg_ok) + int'(msg_err) + int'(err_code), 0);
      chk("R10 strobes", int'(tx_sync) + int'(tx_load) + int'(fifo_rd), 0);
      rst_n = 1'b1;
      void'($urandom(32'd1553));
      repeat (2) @(negedge clk);

      run_msg("rx status-only", mk(5, 0, 3, 4), 16'h0001, 0, -1, 16'h0);
      run_msg("tx 3 words", mk(5, 1, 3, 3), 16'h0001, 3, -1, 16'h0);
      run_msg("tx underrun R4", mk(5, 1, 3, 3), 16'h0001, 1, -1, 16'h0);
      run_msg("tx none R4", mk(5, 1, 3, 2), 16'h0001, 0, -1, 16'h0);
      run_msg("suppress R6", mk(5, 1, 3, 3), 16'h2001, 3, -1, 16'h0);
      run_msg("bcast tx R7", mk(31, 1, 3, 2), 16'h0001, 2, -1, 16'h0);
      run_msg("bcast mode nodata R7", mk(31, 0, 0, 1), 16'h0001, 0, -1, 16'h0);
      run_msg("bcast rx R7", mk(31, 0, 4, 2), 16'h0001, 0, -1, 16'h0);
      run_msg("tx off R8", mk(5, 1, 3, 2), 16'h0000, 2, -1, 16'h0);
      run_msg("mode tx data R3", mk(5, 1, 31, 16), 16'h0001, 1, -1, 16'h0);
      run_msg("supersede early R9", mk(5, 1, 3, 1), 16'h0001, 1, 100, mk(5, 0, 3, 0));
      run_msg("supersede late R9", mk(5, 1, 3, 1), 16'h0001, 1, 300, mk(5, 0, 3, 0));
      run_msg("count zero R3", mk(5, 1, 3, 0), 16'h0001, 32, -1, 16'h0);

      for (int n = 0; n < 10; n++) begin
         int addr, sa, cnt, tx, av;
         logic [15:0] ctl;
         addr = ($urandom % 4 == 0) ? 31 : 7;
         tx = $urandom % 2;
         case ($urandom % 4)
            0: sa = 0;
            1: sa = 31;
            default: sa = 1 + ($urandom % 30);
         endcase
         cnt = (sa == 0 || sa == 31) ? int'($urandom % 32) : 1 + int'($urandom % 3);
         ctl = 16'h0001;
         if ($urandom % 8 == 0) ctl = 16'h0000;
         if ($urandom % 8 == 0) ctl = ctl | 16'h2000;
         av = $urandom % 4;
         run_msg("random", mk(addr, tx, sa, cnt), ctl, av, -1, 16'h0);
      end

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule